// File: doc/BRIEF.md
# Two-Port Shared Byte Memory with Control Decoding

This block is a clocked model of a 4096 x 8 memory shared by two independent ports. Each port presents four active-low controls: chip select (`ce_n`), semaphore select (`sem_n`), output enable (`oe_n`) and a read/write strobe (`rw_n`, low meaning write). Every cycle, each port's control pattern is sorted into one of seven classes:

- memory read or memory write;
- semaphore read or semaphore write;
- powered down;
- outputs muted;
- illegal.

Memory cycles go to a true dual-port byte array that is written so that block RAM can be inferred. Semaphore cycles are passed through to an external semaphore unit. The block sends a strobe, a 3-bit semaphore index and the write bit, and takes back the semaphore bit that unit reports for the current index.

Read results appear on `rdata` one clock after the request, with `rdata_oe` marking the cycles in which the port would drive its data lines. A port that selects the RAM and the semaphore space at the same time gets no access, and its `illegal` flag is raised. Nothing arbitrates between the ports. When both ports write one word in the same cycle, port 0's byte is kept, but users must not depend on that.

Top module: `twoport_mem_access`

## Requirements
- R1: A memory write (`ce_n`=0, `rw_n`=0, `sem_n`=1) stores `wdata` at `addr` on that clock edge, whatever `oe_n` is.
- R2: A memory read (`ce_n`=0, `rw_n`=1, `oe_n`=0, `sem_n`=1) gives the stored byte on `rdata` with `rdata_oe`=1 in the next cycle.
- R3: With `ce_n`=1 and `sem_n`=1 the port is powered down: `rdata_oe` is 0 in the next cycle, and the memory is not changed.
- R4: With `oe_n`=1, `rdata_oe` is 0 in the next cycle for every combination of the other controls.
- R5: `ce_n`=0 together with `sem_n`=0 is illegal. It sets `illegal` for that port in the next cycle, writes no memory, raises no semaphore strobe and leaves `rdata_oe` at 0. The flag clears after the next legal cycle.
- R6: A semaphore write (`ce_n`=1, `sem_n`=0, `rw_n`=0) raises `sem_wr` in the same cycle, with `sem_addr`=`addr[2:0]` and `sem_wbit`=`wdata[0]`. The memory is not changed.
- R7: A semaphore read (`ce_n`=1, `sem_n`=0, `rw_n`=1, `oe_n`=0) raises `sem_rd` in the same cycle. In the next cycle all eight bits of `rdata` equal the `sem_rbit` value sampled at the request, with `rdata_oe`=1.
- R8: A read of a word by one port returns the other port's new byte from the cycle after that port's write. A read in the same cycle as the write returns the previous byte.
- R9: Both ports may write different words in the same cycle, and both writes are kept.
- R10: After reset, `rdata_oe`, `illegal`, `sem_wr` and `sem_rd` are all 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 2 | Memory chip select per port, active low (bit 0 = port 0) |
| sem_n | input | 2 | Semaphore space select per port, active low |
| oe_n | input | 2 | Output enable per port, active low |
| rw_n | input | 2 | Per port: 1 = read, 0 = write |
| addr | input | 2x12 | Word address per port; bits 2:0 index the semaphores |
| wdata | input | 2x8 | Write data per port |
| rdata | output | 2x8 | Read data per port, one cycle after the request |
| rdata_oe | output | 2 | Per port: data lines driven this cycle |
| illegal | output | 2 | Per port: illegal control combination seen the cycle before |
| sem_wr | output | 2 | Per port: semaphore write strobe to the semaphore unit |
| sem_rd | output | 2 | Per port: semaphore read strobe to the semaphore unit |
| sem_addr | output | 2x3 | Semaphore index per port |
| sem_wbit | output | 2 | Semaphore write value per port |
| sem_rbit | input | 2 | Semaphore value returned by the semaphore unit per port |

## Verification
If a control pattern were decoded into the wrong class, it would show at the ports within one cycle. A semaphore strobe would appear or go missing in the same cycle. The drive flag or the illegal flag would be wrong at the next edge. A write that was lost or misplaced has no effect until the word is read back: the bad byte appears one cycle after that read, possibly many cycles later. For that reason every suppressed write is followed by a read of the word it could have touched. Faults in read-before-write ordering between the ports are found by reading a word in the same cycle the other port writes it, and again one cycle later.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic [2:0] {
    CYC_SLEEP,
    CYC_MUTE,
    CYC_MEM_RD,
    CYC_MEM_WR,
    CYC_SEM_RD,
    CYC_SEM_WR,
    CYC_CLASH
  } cyc_e;
endpackage

// File: rtl/tpm_port_decode.sv
module tpm_port_decode
  import tpm_pkg::*;
(
  input  logic ce_n,
  input  logic sem_n,
  input  logic oe_n,
  input  logic rw_n,
  output cyc_e cyc
);
  always_comb begin
    if (!ce_n && !sem_n)  cyc = CYC_CLASH;
    else if (!ce_n)       cyc = !rw_n ? CYC_MEM_WR : (oe_n ? CYC_MUTE : CYC_MEM_RD);
    else if (!sem_n)      cyc = !rw_n ? CYC_SEM_WR : (oe_n ? CYC_MUTE : CYC_SEM_RD);
    else                  cyc = CYC_SLEEP;
  end
endmodule

// File: rtl/tpm_ram.sv
module tpm_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_a,
  input  logic              re_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wd_a,
  output logic [DATA_W-1:0] q_a,
  input  logic              we_b,
  input  logic              re_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wd_b,
  output logic [DATA_W-1:0] q_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port a is written last so its byte survives a same-word collision.
  always_ff @(posedge clk) begin
    if (we_b) mem[addr_b] <= wd_b;
    if (we_a) mem[addr_a] <= wd_a;
  end

  // Read-first: a read sees the array as it was before this edge's writes.
  always_ff @(posedge clk) begin
    if (re_a) q_a <= mem[addr_a];
  end

  always_ff @(posedge clk) begin
    if (re_b) q_b <= mem[addr_b];
  end
endmodule

// File: rtl/tpm_port_out.sv
module tpm_port_out
  import tpm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              cyc,
  input  logic [DATA_W-1:0] ram_q,
  input  logic              sem_bit,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              illegal
);
  logic drive_q, pick_sem_q, sem_q, bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q    <= 1'b0;
      pick_sem_q <= 1'b0;
      sem_q      <= 1'b0;
      bad_q      <= 1'b0;
    end else begin
      drive_q    <= (cyc == CYC_MEM_RD) || (cyc == CYC_SEM_RD);
      pick_sem_q <= (cyc == CYC_SEM_RD);
      bad_q      <= (cyc == CYC_CLASH);
      if (cyc == CYC_SEM_RD) sem_q <= sem_bit;
    end
  end

  assign rdata    = pick_sem_q ? {DATA_W{sem_q}} : ram_q;
  assign rdata_oe = drive_q;
  assign illegal  = bad_q;
endmodule

// File: rtl/twoport_mem_access.sv
module twoport_mem_access
  import tpm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int SEM_AW = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             ce_n,
  input  logic [1:0]             sem_n,
  input  logic [1:0]             oe_n,
  input  logic [1:0]             rw_n,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0][DATA_W-1:0] wdata,
  output logic [1:0][DATA_W-1:0] rdata,
  output logic [1:0]             rdata_oe,
  output logic [1:0]             illegal,
  output logic [1:0]             sem_wr,
  output logic [1:0]             sem_rd,
  output logic [1:0][SEM_AW-1:0] sem_addr,
  output logic [1:0]             sem_wbit,
  input  logic [1:0]             sem_rbit
);
  localparam int NPORT = 2;

  cyc_e                   cyc [NPORT];
  logic [NPORT-1:0]       ram_we, ram_re;
  logic [1:0][DATA_W-1:0] ram_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    tpm_port_decode u_dec (
      .ce_n  (ce_n[p]),
      .sem_n (sem_n[p]),
      .oe_n  (oe_n[p]),
      .rw_n  (rw_n[p]),
      .cyc   (cyc[p])
    );

    assign ram_we[p]   = (cyc[p] == CYC_MEM_WR);
    assign ram_re[p]   = (cyc[p] == CYC_MEM_RD);
    assign sem_wr[p]   = (cyc[p] == CYC_SEM_WR);
    assign sem_rd[p]   = (cyc[p] == CYC_SEM_RD);
    assign sem_addr[p] = addr[p][SEM_AW-1:0];
    assign sem_wbit[p] = wdata[p][0];

    tpm_port_out #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst      (rst),
      .cyc      (cyc[p]),
      .ram_q    (ram_q[p]),
      .sem_bit  (sem_rbit[p]),
      .rdata    (rdata[p]),
      .rdata_oe (rdata_oe[p]),
      .illegal  (illegal[p])
    );
  end

  tpm_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .we_a   (ram_we[0]),
    .re_a   (ram_re[0]),
    .addr_a (addr[0]),
    .wd_a   (wdata[0]),
    .q_a    (ram_q[0]),
    .we_b   (ram_we[1]),
    .re_b   (ram_re[1]),
    .addr_b (addr[1]),
    .wd_b   (wdata[1]),
    .q_b    (ram_q[1])
  );
endmodule

// File: rtl/tpm_chk.sv
module tpm_chk #(
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             ce_n,
  input logic [1:0]             sem_n,
  input logic [1:0]             oe_n,
  input logic [1:0]             rw_n,
  input logic [1:0][DATA_W-1:0] rdata,
  input logic [1:0]             rdata_oe,
  input logic [1:0]             illegal,
  input logic [1:0]             sem_wr,
  input logic [1:0]             sem_rd,
  input logic [1:0]             sem_rbit
);
  for (genvar p = 0; p < 2; p++) begin : g_chk
    // R5
    clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (!ce_n[p] && !sem_n[p]) |=> (illegal[p] && !rdata_oe[p]));
    // R5
    clash_no_sem_chk: assert property (@(posedge clk) disable iff (rst)
      (!ce_n[p] && !sem_n[p]) |-> (!sem_wr[p] && !sem_rd[p]));
    // R3
    sleep_undriven_chk: assert property (@(posedge clk) disable iff (rst)
      (ce_n[p] && sem_n[p]) |=> !rdata_oe[p]);
    // R4
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
      oe_n[p] |=> !rdata_oe[p]);
    // R2
    mem_rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (!ce_n[p] && sem_n[p] && rw_n[p] && !oe_n[p]) |=> rdata_oe[p]);
    // R7
    sem_rd_data_chk: assert property (@(posedge clk) disable iff (rst)
      (ce_n[p] && !sem_n[p] && rw_n[p] && !oe_n[p])
        |=> (rdata_oe[p] && rdata[p] == {DATA_W{$past(sem_rbit[p])}}));
  end
endmodule

bind twoport_mem_access tpm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n),
  .sem_n    (sem_n),
  .oe_n     (oe_n),
  .rw_n     (rw_n),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .illegal  (illegal),
  .sem_wr   (sem_wr),
  .sem_rd   (sem_rd),
  .sem_rbit (sem_rbit)
);

// File: tb/twoport_mem_access_tb.sv
module twoport_mem_access_tb;
  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       ce_n, sem_n, oe_n, rw_n;
  logic [1:0][11:0] addr;
  logic [1:0][7:0]  wdata;
  logic [1:0][7:0]  rdata;
  logic [1:0]       rdata_oe, illegal, sem_wr, sem_rd, sem_wbit, sem_rbit;
  logic [1:0][2:0]  sem_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  twoport_mem_access u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .sem_n(sem_n), .oe_n(oe_n), .rw_n(rw_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .illegal(illegal), .sem_wr(sem_wr), .sem_rd(sem_rd), .sem_addr(sem_addr),
    .sem_wbit(sem_wbit), .sem_rbit(sem_rbit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int p);
    ce_n[p] = 1'b1; sem_n[p] = 1'b1; oe_n[p] = 1'b1; rw_n[p] = 1'b1;
    addr[p] = '0;   wdata[p] = '0;
  endtask

  task automatic set(input int p, input logic c, input logic s, input logic o,
                     input logic w, input logic [11:0] a, input logic [7:0] d);
    ce_n[p] = c; sem_n[p] = s; oe_n[p] = o; rw_n[p] = w; addr[p] = a; wdata[p] = d;
  endtask

  task automatic mem_write(input int p, input logic [11:0] a, input logic [7:0] d);
    set(p, 0, 1, 1, 0, a, d);
    tick();
    idle(p);
  endtask

  task automatic mem_read_chk(input int p, input logic [11:0] a, input logic [7:0] exp,
                              input string req);
    set(p, 0, 1, 0, 1, a, 8'h00);
    tick();
    idle(p);
    chk(req, {31'd0, rdata_oe[p]}, 32'd1);
    chk(req, {24'd0, rdata[p]}, {24'd0, exp});
  endtask

  task automatic t_reset();
    chk("R10 oe",      {30'd0, rdata_oe}, 0);
    chk("R10 illegal", {30'd0, illegal},  0);
    chk("R10 sem",     {28'd0, sem_wr, sem_rd}, 0);
  endtask

  task automatic t_write_read();
    set(0, 0, 1, 0, 0, 12'h123, 8'hA5);   // R1: write with oe_n low still writes
    tick(); idle(0);
    mem_read_chk(0, 12'h123, 8'hA5, "R1/R2 port0 readback");
    mem_read_chk(1, 12'h123, 8'hA5, "R2 port1 reads port0 byte");
  endtask

  task automatic t_flow();
    mem_write(0, 12'h200, 8'h11);
    set(1, 0, 1, 1, 0, 12'h200, 8'h3C);
    set(0, 0, 1, 0, 1, 12'h200, 8'h00);
    tick(); idle(0); idle(1);
    chk("R8 same-cycle read old", {24'd0, rdata[0]}, 32'h11);
    mem_read_chk(0, 12'h200, 8'h3C, "R8 next-cycle read new");
  endtask

  task automatic t_dual_write();
    set(0, 0, 1, 1, 0, 12'h010, 8'h01);
    set(1, 0, 1, 1, 0, 12'hFFF, 8'h02);
    tick(); idle(0); idle(1);
    mem_read_chk(1, 12'h010, 8'h01, "R9 port0 word");
    mem_read_chk(0, 12'hFFF, 8'h02, "R9 port1 word");
  endtask

  task automatic t_sleep();
    set(0, 1, 1, 0, 0, 12'h123, 8'hFF);
    tick(); idle(0);
    chk("R3 undriven", {31'd0, rdata_oe[0]}, 0);
    mem_read_chk(0, 12'h123, 8'hA5, "R3 no write");
  endtask

  task automatic t_oe_high();
    set(1, 0, 1, 1, 1, 12'h123, 8'h00);
    tick(); idle(1);
    chk("R4 mem read oe high", {31'd0, rdata_oe[1]}, 0);
    set(1, 1, 0, 1, 1, 12'h001, 8'h00);
    tick(); idle(1);
    chk("R4 sem read oe high", {31'd0, rdata_oe[1]}, 0);
  endtask

  task automatic t_illegal();
    set(1, 0, 0, 0, 0, 12'h123, 8'h00);
    #1;
    chk("R5 no sem strobe", {30'd0, sem_wr[1], sem_rd[1]}, 0);
    tick(); idle(1);
    chk("R5 flag", {31'd0, illegal[1]}, 1);
    chk("R5 undriven", {31'd0, rdata_oe[1]}, 0);
    mem_read_chk(1, 12'h123, 8'hA5, "R5 no write");
    chk("R5 flag clears", {31'd0, illegal[1]}, 0);
  endtask

  task automatic t_sem_write();
    mem_write(1, 12'hFF5, 8'h77);
    set(1, 1, 0, 1, 0, 12'hFF5, 8'h01);
    #1;
    chk("R6 strobe", {31'd0, sem_wr[1]}, 1);
    chk("R6 index",  {29'd0, sem_addr[1]}, 5);
    chk("R6 bit",    {31'd0, sem_wbit[1]}, 1);
    tick(); idle(1);
    mem_read_chk(1, 12'hFF5, 8'h77, "R6 no write");
  endtask

  task automatic t_sem_read();
    sem_rbit = 2'b01;
    set(0, 1, 0, 0, 1, 12'h003, 8'h00);
    #1;
    chk("R7 strobe", {31'd0, sem_rd[0]}, 1);
    tick(); idle(0);
    sem_rbit = 2'b00;
    chk("R7 one",    {24'd0, rdata[0]}, 32'hFF);
    chk("R7 oe",     {31'd0, rdata_oe[0]}, 1);
    set(0, 1, 0, 0, 1, 12'h003, 8'h00);
    tick(); idle(0);
    chk("R7 zero",   {24'd0, rdata[0]}, 32'h00);
  endtask

  initial begin
    idle(0); idle(1);
    sem_rbit = 2'b00;
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_flow();
    t_dual_write();
    t_sleep();
    t_oe_high();
    t_illegal();
    t_sem_write();
    t_sem_read();
    tick();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule